// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

This block sends colour frames to a chain of daisy-chained RGB LEDs over a single serial wire. A pulse on the start input opens a frame. The block first holds the wire low for a reset interval, which tells the chain that a new frame follows. It then sends one 24-bit colour word per LED, back to back, beginning with the LED nearest the driver.

The block does not store any colour. It puts an LED index on its address port and takes the 24-bit word for that index from outside logic. That logic can be a combinational colour generator or a memory with one cycle of read latency. The address of the next LED is set up while the current word is still being sent. The new word is captured at the moment the current word ends, so no gap opens between LEDs.

Each bit is sent as a high period followed by a low period. The two lengths tell a 0 bit from a 1 bit. The reset interval and all four pulse lengths are build-time parameters counted in system clock cycles, so one design can suit different LED models.

Top module: `ledchain_drv`

## Requirements
- R1: Out of reset, and whenever no frame is running, `dout_o` is 0 and `busy_o` is 0.
- R2: A start pulse sampled while idle sets `busy_o` from the next cycle. `dout_o` then stays 0 for exactly `RST_CYC` cycles. `RST_CYC` must be at least 2.
- R3: A 1 bit is sent as `T1H_CYC` cycles high followed by `T1L_CYC` cycles low. A 0 bit is sent as `T0H_CYC` cycles high followed by `T0L_CYC` cycles low.
- R4: Each LED receives 24 bits, most significant bit first. The word is laid out as three 8-bit channels in bits [23:16], [15:8] and [7:0], and is passed on unchanged. Consecutive bits and consecutive words follow each other with no idle cycles.
- R5: Words are sent in index order 0 to `NUM_LEDS`-1, and word k is the value returned for address k. `addr_o` holds k for at least one cycle before word k is captured, so a memory with one cycle of read latency can supply the data.
- R6: The frame ends when the low period of the last bit of LED `NUM_LEDS`-1 is over. In the next cycle `busy_o` is 0 and `dout_o` is 0.
- R7: A start pulse that arrives while `busy_o` is 1 has no effect. The running frame keeps its length and content, and no second frame follows it.
- R8: `busy_o` stays 1 without a break from the first reset cycle through the last data cycle.
- R9: `addr_o` never goes above `NUM_LEDS`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, taken only while idle |
| color_i | input | 24 | Colour word for the LED at `addr_o` |
| busy_o | output | 1 | High while a frame is in progress |
| addr_o | output | max(1, clog2(NUM_LEDS)) | Index of the LED whose colour is being fetched |
| dout_o | output | 1 | Serial line to the first LED |

## Verification
The testbench models the colour source as a memory with one cycle of read latency. If the address moved too late, the first bit of a word would carry the previous LED's colour; if the capture were misplaced, words would be shifted by one LED. Two uneven test patterns catch these faults. Alternating all-ones and all-zeros words test every pulse length and the joins between words, so swapped high and low counts or an off-by-one in the bit counter show up as a wrong cycle. A start pulse in the middle of a frame tests R7: a driver that restarted or queued a second frame would keep `busy_o` high past the expected end.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;

  localparam int unsigned COLOR_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RST  = 2'd1,
    ST_HI   = 2'd2,
    ST_LO   = 2'd3
  } drv_st_e;

endpackage

// File: rtl/ledchain_timer.sv
module ledchain_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/ledchain_word.sv
module ledchain_word #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              msb_o,
  output logic              next_msb_o,
  output logic              last_o
);

  localparam int unsigned BC_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic              en;

  always_comb begin
    en   = load_i || shift_i;
    sh_d = sh_q;
    bc_d = bc_q;
    if (load_i) begin
      sh_d = data_i;
      bc_d = BC_W'(WORD_W - 1);
    end else if (shift_i) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
      bc_d = bc_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      bc_q <= '0;
    end else if (en) begin
      sh_q <= sh_d;
      bc_q <= bc_d;
    end
  end

  assign msb_o      = sh_q[WORD_W-1];
  assign next_msb_o = sh_q[WORD_W-2];
  assign last_o     = (bc_q == '0);

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i)); // R4
  AST_NO_SHIFT_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (bc_q != '0)); // R4

endmodule

// File: rtl/ledchain_index.sv
module ledchain_index #(
  parameter int unsigned NUM_LEDS = 8,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_LEDS - 1);

  logic [ADDR_W-1:0] fetch_q, fetch_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              en;

  always_comb begin
    en      = clr_i || adv_i;
    fetch_d = fetch_q;
    cur_d   = cur_q;
    if (clr_i) begin
      fetch_d = '0;
      cur_d   = '0;
    end else if (adv_i) begin
      cur_d   = fetch_q;
      fetch_d = (fetch_q == LAST_IDX) ? fetch_q : fetch_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= '0;
      cur_q   <= '0;
    end else if (en) begin
      fetch_q <= fetch_d;
      cur_q   <= cur_d;
    end
  end

  assign addr_o = fetch_q;
  assign last_o = (cur_q == LAST_IDX);

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (fetch_q == $past(fetch_q))); // R5
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_q <= LAST_IDX); // R9

endmodule

// File: rtl/ledchain_drv.sv
module ledchain_drv
  import ledchain_pkg::*;
#(
  parameter int unsigned NUM_LEDS = 8,
  parameter int unsigned T0H_CYC  = 100,
  parameter int unsigned T0L_CYC  = 212,
  parameter int unsigned T1H_CYC  = 200,
  parameter int unsigned T1L_CYC  = 112,
  parameter int unsigned RST_CYC  = 12500,
  localparam int unsigned ADDR_W  = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COLOR_W-1:0] color_i,
  output logic               busy_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               dout_o
);

  localparam int unsigned MAX_A = (T0H_CYC > T0L_CYC) ? T0H_CYC : T0L_CYC;
  localparam int unsigned MAX_B = (T1H_CYC > T1L_CYC) ? T1H_CYC : T1L_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_D = (MAX_C > RST_CYC) ? MAX_C : RST_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_D) + 1;

  localparam logic [CNT_W-1:0] LD_RST = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] LD_0H  = CNT_W'(T0H_CYC - 1);
  localparam logic [CNT_W-1:0] LD_0L  = CNT_W'(T0L_CYC - 1);
  localparam logic [CNT_W-1:0] LD_1H  = CNT_W'(T1H_CYC - 1);
  localparam logic [CNT_W-1:0] LD_1L  = CNT_W'(T1L_CYC - 1);

  drv_st_e          st_q, st_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             w_load, w_shift;
  logic             w_msb, w_next_msb, w_last;
  logic             idx_clr, idx_adv, idx_last;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    w_load   = 1'b0;
    w_shift  = 1'b0;
    idx_clr  = 1'b0;
    idx_adv  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_RST;
          tmr_load = 1'b1;
          tmr_val  = LD_RST;
          idx_clr  = 1'b1;
        end
      end
      ST_RST: begin
        if (tmr_zero) begin
          st_d     = ST_HI;
          w_load   = 1'b1;
          idx_adv  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = color_i[COLOR_W-1] ? LD_1H : LD_0H;
        end
      end
      ST_HI: begin
        if (tmr_zero) begin
          st_d     = ST_LO;
          tmr_load = 1'b1;
          tmr_val  = w_msb ? LD_1L : LD_0L;
        end
      end
      ST_LO: begin
        if (tmr_zero) begin
          if (w_last) begin
            if (idx_last) begin
              st_d = ST_IDLE;
            end else begin
              st_d     = ST_HI;
              w_load   = 1'b1;
              idx_adv  = 1'b1;
              tmr_load = 1'b1;
              tmr_val  = color_i[COLOR_W-1] ? LD_1H : LD_0H;
            end
          end else begin
            st_d     = ST_HI;
            w_shift  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = w_next_msb ? LD_1H : LD_0H;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  ledchain_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  ledchain_word #(
    .WORD_W(COLOR_W)
  ) u_word (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (w_load),
    .shift_i   (w_shift),
    .data_i    (color_i),
    .msb_o     (w_msb),
    .next_msb_o(w_next_msb),
    .last_o    (w_last)
  );

  ledchain_index #(
    .NUM_LEDS(NUM_LEDS),
    .ADDR_W  (ADDR_W)
  ) u_index (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (idx_clr),
    .adv_i (idx_adv),
    .addr_o(addr_o),
    .last_o(idx_last)
  );

  assign busy_o = (st_q != ST_IDLE);
  assign dout_o = (st_q == ST_HI);

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dout_o); // R1
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RST) |-> (!dout_o && busy_o)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(st_q == ST_LO && tmr_zero && w_last && idx_last)) |=> busy_o); // R8

endmodule

// File: tb/tb_ledchain_drv.sv
module tb_ledchain_drv;

  localparam int N   = 3;
  localparam int T0H = 2;
  localparam int T0L = 5;
  localparam int T1H = 4;
  localparam int T1L = 3;
  localparam int TR  = 6;
  localparam int AW  = (N > 1) ? $clog2(N) : 1;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [23:0]   mem_q;
  logic          busy;
  logic [AW-1:0] addr;
  logic          dout;
  int            pat;
  int            checks;
  int            errors;
  bit            q_d[$];
  int            q_t[$];

  ledchain_drv #(
    .NUM_LEDS(N), .T0H_CYC(T0H), .T0L_CYC(T0L),
    .T1H_CYC(T1H), .T1L_CYC(T1L), .RST_CYC(TR)
  ) dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .color_i(mem_q),
    .busy_o (busy),
    .addr_o (addr),
    .dout_o (dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [23:0] colf(int a, int p);
    case (p)
      0:       colf = (a % 2 == 0) ? 24'hFFFFFF : 24'h000000;
      1:       colf = {8'(a * 53 + 7), 8'(a * 29 + 200), 8'(a ^ 8'hA5)};
      default: colf = 24'h800001 ^ (24'(a) << 9);
    endcase
  endfunction

  // colour source: memory with one cycle of read latency
  always @(posedge clk) mem_q <= colf(int'(addr), pat);

  // reference model: builds the expected line sequence when a frame is accepted
  always @(posedge clk) begin
    if (!rst_n) begin
      q_d.delete();
      q_t.delete();
    end else if (start && q_d.size() == 0) begin
      for (int i = 0; i < TR; i++) begin q_d.push_back(1'b0); q_t.push_back(2); end
      for (int k = 0; k < N; k++) begin
        logic [23:0] w;
        w = colf(k, pat);
        for (int b = 23; b >= 0; b--) begin
          int hi, lo;
          hi = w[b] ? T1H : T0H;
          lo = w[b] ? T1L : T0L;
          for (int c = 0; c < hi; c++) begin
            q_d.push_back(1'b1);
            q_t.push_back((b == 23 && c == 0) ? 5 : 3);
          end
          for (int c = 0; c < lo; c++) begin q_d.push_back(1'b0); q_t.push_back(3); end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_d, exp_b;
      int tg;
      if (q_d.size() != 0) begin
        exp_d = q_d.pop_front();
        tg    = q_t.pop_front();
        exp_b = 1'b1;
      end else begin
        exp_d = 1'b0;
        exp_b = 1'b0;
        tg    = 6;
      end
      checks++;
      if (dout !== exp_d) begin
        errors++;
        case (tg)
          2: $display("FAIL R2 reset low: dout=%b exp=%b t=%0t", dout, exp_d, $time);
          3: $display("FAIL R3 R4 bit stream: dout=%b exp=%b t=%0t", dout, exp_d, $time);
          5: $display("FAIL R5 word start: dout=%b exp=%b t=%0t", dout, exp_d, $time);
          default: $display("FAIL R1 R6 R7 idle line: dout=%b exp=%b t=%0t", dout, exp_d, $time);
        endcase
      end
      checks++;
      if (busy !== exp_b) begin
        errors++;
        $display("FAIL R8 R6 R7 busy: busy=%b exp=%b t=%0t", busy, exp_b, $time);
      end
      checks++;
      if (int'(addr) > N - 1) begin
        errors++;
        $display("FAIL R9 addr range: addr=%0d exp<=%0d", addr, N - 1);
      end
    end
  end

  task automatic run_frame(int p, bit poke_mid);
    @(negedge clk);
    pat   = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_mid) begin
      // R7: start pulses during reset and during data must be ignored
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      start = 1'b1;
      repeat (2) @(negedge clk);
      start = 1'b0;
    end
    while (q_d.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    start  = 1'b0;
    pat    = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (dout !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: dout=%b busy=%b exp=0 0", dout, busy);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(0, 1'b0);
    run_frame(1, 1'b0);
    run_frame(2, 1'b1);
    run_frame(1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule